// File: doc/BRIEF.md
# Half-to-Single Precision Widening Converter

This unit widens a 16-bit half-precision floating-point pattern into a 32-bit single-precision pattern. The conversion is always exact, so the unit does no rounding. The work covers five steps: splitting the input into its fields, classifying the value, normalising subnormals with a leading-zero count, rebiasing the exponent, and building the output for the special values. The result and an invalid-operation flag come out of registers one clock after the input is accepted.

A mode input picks between two input formats. The first is the standard IEEE half format. The second is an extended-range format. It has no infinity or NaN encodings, so it treats an all-ones exponent as an ordinary finite binade. A pipeline feeds one operand per cycle with a qualifying valid strobe. That pipeline reads the widened word and the flag on the following cycle.

Top module: `half_to_single_widen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `single_out` and `invalid_op` are all zero.
- R2: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is low, `single_out` and `invalid_op` keep their previous values.
- R3: A half operand with exponent field `half_in[14:10]` in 1..30 (or 31 in extended mode) gives single exponent = half exponent + 112. The single fraction is `{half_in[9:0], 13'b0}`.
- R4: An operand with `half_in[14:0] == 0` gives a single zero, `single_out[30:0] == 0`, with the input sign kept.
- R5: An operand with exponent 0 and nonzero fraction (a subnormal) is normalised. With p the index of the highest set fraction bit (0..9), the single exponent is 103 + p. The fraction is the input fraction shifted left by 10 − p, kept to 10 bits, then placed in bits 22:13.
- R6: In standard mode (`alt_fmt` = 0), exponent 31 with fraction 0 gives infinity: exponent field 0xFF and fraction field zero.
- R7: In standard mode, exponent 31 with nonzero fraction gives a NaN. The exponent field is 0xFF and the fraction field is `{half_in[9:0] | 10'h200, 13'b0}`, so the quiet bit 22 is always set.
- R8: `invalid_op` is 1 only for a standard-mode operand with exponent 31, nonzero fraction and `half_in[9]` = 0 (a signalling NaN). For every other operand it is 0.
- R9: In extended mode (`alt_fmt` = 1), exponent 31 is an ordinary normal exponent. It gives single exponent 143 (0x8F), and `invalid_op` is never raised in this mode.
- R10: `single_out[31]` always equals `half_in[15]` of the accepted operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| half_in | input | 16 | Half-precision operand |
| alt_fmt | input | 1 | 0 = standard half, 1 = extended-range half |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| single_out | output | 32 | Single-precision result |
| invalid_op | output | 1 | Signalling-NaN input flag |

## Verification
The bench sweeps all 65536 operands in both modes, so every subnormal shift distance is checked, as are the exponent-31 row and both signs.

Each class of bug shows up in a different way:
- An off-by-one leading-zero count would leave the subnormal exponents one binade out, and the hidden bit would land inside the fraction.
- Forgetting the mode would turn every extended-mode top-binade value into an infinity or NaN.
- Not forcing the quiet bit would pass signalling payloads through unchanged.
- A flag that ignores the mode or the quiet bit would fire on quiet NaNs or on finite extended values.

Idle cycles check that the output registers hold their value and that the valid strobe is not stretched.

// File: rtl/h2s_pkg.sv
package h2s_pkg;

  // Kind of value an incoming half operand encodes
  typedef enum logic [2:0] {
    VK_ZERO,
    VK_SUBN,
    VK_NORM,
    VK_INF,
    VK_NAN
  } val_kind_t;

endpackage

// File: rtl/h2s_lzc.sv
// Leading-zero counter for a W-bit field; all-zero input yields W.
module h2s_lzc #(
  parameter int W   = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);

  logic [W:0] seen;   // seen[i]: a one exists at or above bit W-i
  logic [CW-1:0] cnt_part [W+1];

  assign seen[0]     = 1'b0;
  assign cnt_part[0] = '0;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_scan
      assign seen[g+1]     = seen[g] | vec[W-1-g];
      assign cnt_part[g+1] = cnt_part[g] + ((seen[g+1]) ? CW'(0) : CW'(1));
    end
  endgenerate

  assign zeros = cnt_part[W];

endmodule

// File: rtl/h2s_classify.sv
// Sorts a half operand into zero / subnormal / normal / inf / nan.
module h2s_classify
  import h2s_pkg::*;
#(
  parameter int HE = 5,
  parameter int HF = 10
) (
  input  logic [HE-1:0] exp_f,
  input  logic [HF-1:0] frac_f,
  input  logic          ext_mode,
  output val_kind_t     kind
);

  logic exp_zero, exp_full, frac_zero;

  assign exp_zero  = (exp_f == '0);
  assign exp_full  = (exp_f == '1);
  assign frac_zero = (frac_f == '0);

  always_comb begin
    if (exp_zero)
      kind = frac_zero ? VK_ZERO : VK_SUBN;
    else if (exp_full && !ext_mode)
      kind = frac_zero ? VK_INF : VK_NAN;
    else
      kind = VK_NORM;
  end

endmodule

// File: rtl/h2s_assemble.sv
// Builds the wide word from the classified fields.
module h2s_assemble
  import h2s_pkg::*;
#(
  parameter int HE  = 5,
  parameter int HF  = 10,
  parameter int SE  = 8,
  parameter int SF  = 23,
  localparam int CW = $clog2(HF + 1),
  localparam int PAD = SF - HF,
  localparam int BIAS_DELTA = ((2 ** (SE - 1)) - 1) - ((2 ** (HE - 1)) - 1)
) (
  input  logic          sign_f,
  input  logic [HE-1:0] exp_f,
  input  logic [HF-1:0] frac_f,
  input  val_kind_t     kind,
  input  logic [CW-1:0] lead_z,
  output logic [SE+SF:0] word,
  output logic          sig_nan
);

  localparam logic [SE-1:0] BIAS_V = SE'(BIAS_DELTA);
  localparam logic [HF-1:0] QUIET  = {1'b1, {(HF-1){1'b0}}};

  logic [SE-1:0] exp_o;
  logic [HF-1:0] frac_top;
  logic [HF-1:0] sub_frac;
  logic [SF-1:0] frac_o;

  // Drop the leading one by shifting one past the zeros
  assign sub_frac = frac_f << (lead_z + CW'(1));

  always_comb begin
    exp_o    = '0;
    frac_top = '0;
    sig_nan  = 1'b0;
    unique case (kind)
      VK_ZERO: begin
        exp_o    = '0;
        frac_top = '0;
      end
      VK_SUBN: begin
        exp_o    = BIAS_V - SE'(lead_z);
        frac_top = sub_frac;
      end
      VK_NORM: begin
        exp_o    = SE'(exp_f) + BIAS_V;
        frac_top = frac_f;
      end
      VK_INF: begin
        exp_o    = '1;
        frac_top = '0;
      end
      VK_NAN: begin
        exp_o    = '1;
        frac_top = frac_f | QUIET;
        sig_nan  = ~frac_f[HF-1];
      end
      default: begin
        exp_o    = '0;
        frac_top = '0;
      end
    endcase
  end

  generate
    if (PAD > 0) begin : g_pad
      assign frac_o = {frac_top, {PAD{1'b0}}};
    end else begin : g_nopad
      assign frac_o = frac_top[HF-1 -: SF];
    end
  endgenerate

  assign word = {sign_f, exp_o, frac_o};

endmodule

// File: rtl/half_to_single_widen.sv
module half_to_single_widen
  import h2s_pkg::*;
#(
  parameter int HE  = 5,
  parameter int HF  = 10,
  parameter int SE  = 8,
  parameter int SF  = 23,
  localparam int HW = 1 + HE + HF,
  localparam int SW = 1 + SE + SF,
  localparam int CW = $clog2(HF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [HW-1:0] half_in,
  input  logic          alt_fmt,
  output logic          out_valid,
  output logic [SW-1:0] single_out,
  output logic          invalid_op
);

  logic          h_sign;
  logic [HE-1:0] h_exp;
  logic [HF-1:0] h_frac;
  val_kind_t     h_kind;
  logic [CW-1:0] h_lz;
  logic [SW-1:0] w_next;
  logic          inv_next;

  assign h_sign = half_in[HW-1];
  assign h_exp  = half_in[HF +: HE];
  assign h_frac = half_in[HF-1:0];

  h2s_classify #(.HE(HE), .HF(HF)) u_cls (
    .exp_f    (h_exp),
    .frac_f   (h_frac),
    .ext_mode (alt_fmt),
    .kind     (h_kind)
  );

  h2s_lzc #(.W(HF)) u_lzc (
    .vec   (h_frac),
    .zeros (h_lz)
  );

  h2s_assemble #(.HE(HE), .HF(HF), .SE(SE), .SF(SF)) u_asm (
    .sign_f  (h_sign),
    .exp_f   (h_exp),
    .frac_f  (h_frac),
    .kind    (h_kind),
    .lead_z  (h_lz),
    .word    (w_next),
    .sig_nan (inv_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      single_out <= '0;
      invalid_op <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        single_out <= w_next;
        invalid_op <= inv_next;
      end
    end
  end

endmodule

// File: rtl/h2s_chk.sv
module h2s_chk #(
  parameter int HE = 5,
  parameter int HF = 10,
  parameter int SE = 8,
  parameter int SF = 23
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [HE+HF:0]      half_in,
  input logic                alt_fmt,
  input logic                out_valid,
  input logic [SE+SF:0]      single_out,
  input logic                invalid_op
);

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(single_out) && !out_valid));

  // R10
  sign_copy_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (single_out[SE+SF] == $past(half_in[HE+HF])));

  // R4
  zero_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && half_in[HE+HF-1:0] == '0) |=> (single_out[SE+SF-1:0] == '0));

  // R6
  special_exp_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !alt_fmt && half_in[HF +: HE] == '1) |=> (single_out[SF +: SE] == '1));

  // R9
  ext_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && alt_fmt) |=> !invalid_op);

  // R7
  flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    invalid_op |-> (single_out[SF +: SE] == '1 && single_out[SF-1]));

endmodule

bind half_to_single_widen h2s_chk #(.HE(HE), .HF(HF), .SE(SE), .SF(SF)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .half_in    (half_in),
  .alt_fmt    (alt_fmt),
  .out_valid  (out_valid),
  .single_out (single_out),
  .invalid_op (invalid_op)
);

// File: tb/half_to_single_widen_tb.sv
module half_to_single_widen_tb;

  typedef struct {
    logic [31:0] word;
    logic        inv;
    string       tag;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] half_in = '0;
  logic        alt_fmt = 1'b0;
  logic        out_valid;
  logic [31:0] single_out;
  logic        invalid_op;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;
  exp_item_t sb[$];
  logic [31:0] last_word = '0;
  logic        last_inv  = 1'b0;

  always #4 clk = ~clk;

  half_to_single_widen u_dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .half_in    (half_in),
    .alt_fmt    (alt_fmt),
    .out_valid  (out_valid),
    .single_out (single_out),
    .invalid_op (invalid_op)
  );

  // Reference model written from the requirements
  function automatic exp_item_t model(input logic [15:0] h, input logic alt);
    exp_item_t r;
    logic       s = h[15];
    logic [4:0] e = h[14:10];
    logic [9:0] f = h[9:0];
    int p = 0;
    logic [9:0] nf;
    r.inv = 1'b0;
    if (!alt && e == 5'd31) begin
      if (f == '0) begin
        r.word = {s, 8'hFF, 23'd0};
        r.tag  = "R6";
      end else begin
        r.word = {s, 8'hFF, f | 10'h200, 13'd0};
        r.inv  = ~f[9];
        r.tag  = "R7";
      end
    end else if (e == 5'd0 && f == '0) begin
      r.word = {s, 31'd0};
      r.tag  = "R4";
    end else if (e == 5'd0) begin
      for (int i = 0; i < 10; i++) if (f[i]) p = i;
      nf = 10'(f << (10 - p));
      r.word = {s, 8'(103 + p), nf, 13'd0};
      r.tag  = "R5";
    end else begin
      r.word = {s, 8'(e) + 8'd112, f, 13'd0};
      r.tag  = (e == 5'd31) ? "R9" : "R3";
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic drive(input logic [15:0] h, input logic alt);
    @(negedge clk);
    half_in  = h;
    alt_fmt  = alt;
    in_valid = 1'b1;
    sb.push_back(model(h, alt));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compares each result against the front of the scoreboard
  initial begin
    exp_item_t e;
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        if (sb.size() == 0) begin
          check("R2 unexpected out_valid", 32'd1, 32'd0);
        end else begin
          e = sb.pop_front();
          if (single_out[31] !== e.word[31])
            check("R10", {31'd0, single_out[31]}, {31'd0, e.word[31]});
          else
            check(e.tag, single_out, e.word);
          // R8 flag compared for every operand
          check("R8", {31'd0, invalid_op}, {31'd0, e.inv});
          last_word = e.word;
          last_inv  = e.inv;
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 valid", {31'd0, out_valid}, 32'd0);
    check("R1 word", single_out, 32'd0);
    check("R1 flag", {31'd0, invalid_op}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after", {out_valid, invalid_op, single_out[29:0]}, 32'd0);

    // Directed corner cases
    drive(16'h3C00, 1'b0);  // R3 one -> 3F800000
    drive(16'h8000, 1'b0);  // R4 negative zero
    drive(16'h0001, 1'b0);  // R5 smallest subnormal -> 33800000
    drive(16'h0200, 1'b1);  // R5 largest-bit subnormal
    drive(16'h7C00, 1'b0);  // R6 +inf
    drive(16'hFC00, 1'b0);  // R6 -inf, R10
    drive(16'h7C01, 1'b0);  // R7 R8 signalling NaN
    drive(16'h7E00, 1'b0);  // R7 quiet NaN, no flag
    drive(16'h7C00, 1'b1);  // R9 -> 47800000
    drive(16'h7FFF, 1'b1);  // R9 -> 47FFE000
    idle(3);
    // R2: idle cycles keep the last result and drop the strobe
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    check("R2 idle hold", single_out, 32'h47FFE000);

    // Exhaustive sweep in both modes
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 65536; v++)
        drive(16'(v), 1'(m));
    idle(3);
    check("R2 final valid", {31'd0, out_valid}, 32'd0);
    check("R2 final hold", single_out, last_word);
    check("R2 final flag", {31'd0, invalid_op}, {31'd0, last_inv});
    check("R2 drained", 32'(sb.size()), 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule